// File: doc/BRIEF.md
# MIDI UART-Mode Host Port

This block gives a host a byte-wide window onto a serial MIDI link, in the style of the UART mode of a classic MIDI processing unit. The host sees two byte locations, chosen by a select line. Location 0 is the data register. A write there queues a byte for the transmitter, and a read there takes the oldest received byte or command acknowledge. Location 1 takes commands on write and returns a status byte on read.

Only two command codes are decoded. Every recognised command places an acknowledge byte 0xFE in the receive buffer. The reset command also flushes both buffers and leaves UART mode. In UART mode the transmit side sends 8N1 frames, and the receive side samples each incoming bit in its middle and queues every frame that has a valid stop bit. A parameter sets the bit period in clock cycles: 1600 cycles gives 31250 baud from a 50 MHz clock. Two level interrupt requests report a drained transmit buffer and waiting receive data.

Top module: `midi_uart_port`

## Requirements
- R1: After reset, status reads 0x80, tx_o is high, both interrupt requests are low and the port is outside UART mode.
- R2: A write of 0x3F to location 1 enters UART mode and queues the acknowledge 0xFE, which the next data read returns.
- R3: A write of 0xFF to location 1 flushes both buffers, leaves UART mode and then queues exactly one 0xFE.
- R4: A write of any other value to location 1 changes neither the mode nor the buffers.
- R5: Status bit 7 is 0 exactly when the receive buffer holds a byte. Status bit 6 is 1 exactly when the transmit buffer is full. Bits 5..0 read 0.
- R6: The transmitter sends bytes in write order as 8N1 frames, LSB first. Each frame has a low start bit and a high stop bit, and each bit lasts CLKS_PER_BIT cycles. The line idles high.
- R7: In UART mode each received frame is sampled mid-bit, and its byte is queued in arrival order.
- R8: A received frame whose stop bit is low is dropped, and the next good frame is still received.
- R9: Each buffer holds DEPTH bytes. A data write to a full transmit buffer is ignored, and a byte received into a full receive buffer is discarded.
- R10: tx_irq_o is high while in UART mode with an empty transmit buffer. rx_irq_o is high while the receive buffer is not empty.
- R11: Outside UART mode, data writes and received frames are ignored.
- R12: A data read from an empty receive buffer returns 0x00 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Location select: 0 data, 1 command/status |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe (pops on a data read) |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data for the selected location |
| rx_i | input | 1 | Serial MIDI input |
| tx_o | output | 1 | Serial MIDI output |
| tx_irq_o | output | 1 | Transmit buffer empty request |
| rx_irq_o | output | 1 | Receive data waiting request |

## Verification
On every cycle, the assertions check the command effects: acknowledge presence, the reset flush count and mode, and a stable mode under an unknown code. They also check buffer occupancy bounds, the idle line, gating of the transmit request by the mode, and that data writes have no effect outside UART mode. Only the bench scenarios can show frame timing and bit order on the line, mid-bit reception and rejection of bad stop bits, arrival ordering, discard on a full buffer, and the exact values of the status byte after each sequence.

// File: rtl/midi_port_pkg.sv
package midi_port_pkg;
  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] CMD_UART  = 8'h3F;
  localparam logic [7:0] ACK_BYTE  = 8'hFE;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;
  logic [PW-1:0] waddr;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (count == '0);
  assign full_o  = (count == CW'(DEPTH));
  assign count_o = count;
  assign dout_o  = mem[rd_ptr];

  // flush has priority; a push in the flush cycle lands in slot 0
  assign do_push = push_i && (flush_i || !full_o);
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign waddr   = flush_i ? '0 : wr_ptr;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[waddr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush_i) begin
      rd_ptr <= '0;
      wr_ptr <= do_push ? inc('0) : '0;
      count  <= do_push ? CW'(1) : '0;
    end else begin
      if (do_push) wr_ptr <= inc(wr_ptr);
      if (do_pop)  rd_ptr <= inc(rd_ptr);
      if (do_push && !do_pop) count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/midi_tx.sv
module midi_tx #(
  parameter int CLKS_PER_BIT = 1600,
  localparam int CW = $clog2(CLKS_PER_BIT + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic       pop_o,
  output logic       tx_o,
  output logic       busy_o
);
  logic [8:0]    shreg;
  logic [3:0]    bit_cnt;
  logic [CW-1:0] clk_cnt;

  assign pop_o = valid_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg   <= '1;
      bit_cnt <= '0;
      clk_cnt <= '0;
      tx_o    <= 1'b1;
      busy_o  <= 1'b0;
    end else if (pop_o) begin
      shreg   <= {1'b1, data_i};
      bit_cnt <= '0;
      clk_cnt <= '0;
      tx_o    <= 1'b0;
      busy_o  <= 1'b1;
    end else if (busy_o) begin
      if (clk_cnt == CW'(CLKS_PER_BIT - 1)) begin
        clk_cnt <= '0;
        if (bit_cnt == 4'd9) begin
          busy_o <= 1'b0;
          tx_o   <= 1'b1;
        end else begin
          tx_o    <= shreg[0];
          shreg   <= {1'b1, shreg[8:1]};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else begin
        clk_cnt <= clk_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/midi_rx.sv
module midi_rx
  import midi_port_pkg::*;
#(
  parameter int CLKS_PER_BIT = 1600,
  localparam int CW   = $clog2(CLKS_PER_BIT + 1),
  localparam int HALF = CLKS_PER_BIT / 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  logic          s1, s2;
  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic [2:0]    bit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rx_i;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (state)
        RX_IDLE: if (!s2) begin
          state <= RX_START;
          cnt   <= '0;
        end
        RX_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt     <= '0;
            bit_idx <= '0;
            state   <= s2 ? RX_IDLE : RX_DATA;
          end else cnt <= cnt + 1'b1;
        end
        RX_DATA: begin
          if (cnt == CW'(CLKS_PER_BIT - 1)) begin
            cnt    <= '0;
            data_o <= {s2, data_o[7:1]};
            if (bit_idx == 3'd7) state <= RX_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        RX_STOP: begin
          if (cnt == CW'(CLKS_PER_BIT - 1)) begin
            cnt <= '0;
            if (s2) begin
              valid_o <= 1'b1;
              state   <= RX_IDLE;
            end else begin
              state <= RX_HOLD;  // bad stop: wait for line to go high
            end
          end else cnt <= cnt + 1'b1;
        end
        RX_HOLD: if (s2) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/midi_uart_port.sv
module midi_uart_port
  import midi_port_pkg::*;
#(
  parameter int CLKS_PER_BIT = 1600,
  parameter int DEPTH        = 4,
  localparam int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       rx_i,
  output logic       tx_o,
  output logic       tx_irq_o,
  output logic       rx_irq_o
);
  logic             uart_mode;
  logic             cmd_wr, is_reset, is_uart, ack;
  logic             rx_valid;
  logic [7:0]       rx_byte;
  logic             rx_push, rx_empty, rx_full;
  logic [7:0]       rx_din, rx_head;
  logic [CNT_W-1:0] rx_count;
  logic             tx_push, tx_pop, tx_empty, tx_full, tx_busy;
  logic [7:0]       tx_head;
  logic [CNT_W-1:0] tx_count;

  assign cmd_wr   = wr_i && sel_i;
  assign is_reset = cmd_wr && (wdata_i == CMD_RESET);
  assign is_uart  = cmd_wr && (wdata_i == CMD_UART);
  assign ack      = is_reset || is_uart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) uart_mode <= 1'b0;
    else if (is_reset) uart_mode <= 1'b0;
    else if (is_uart) uart_mode <= 1'b1;
  end

  // acknowledge wins over a byte finishing in the same cycle
  assign rx_push = ack || (rx_valid && uart_mode);
  assign rx_din  = ack ? ACK_BYTE : rx_byte;
  assign tx_push = wr_i && !sel_i && uart_mode;

  byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (is_reset),
    .push_i  (rx_push),
    .din_i   (rx_din),
    .pop_i   (rd_i && !sel_i),
    .dout_o  (rx_head),
    .empty_o (rx_empty),
    .full_o  (rx_full),
    .count_o (rx_count)
  );

  byte_fifo #(.DEPTH(DEPTH), .W(8)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (is_reset),
    .push_i  (tx_push),
    .din_i   (wdata_i),
    .pop_i   (tx_pop),
    .dout_o  (tx_head),
    .empty_o (tx_empty),
    .full_o  (tx_full),
    .count_o (tx_count)
  );

  midi_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (!tx_empty),
    .data_i  (tx_head),
    .pop_o   (tx_pop),
    .tx_o    (tx_o),
    .busy_o  (tx_busy)
  );

  midi_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rx_i    (rx_i),
    .valid_o (rx_valid),
    .data_o  (rx_byte)
  );

  assign rdata_o  = sel_i    ? {rx_empty, tx_full, 6'b0}
                  : rx_empty ? 8'h00 : rx_head;
  assign tx_irq_o = uart_mode && tx_empty;
  assign rx_irq_o = !rx_empty;
endmodule

// File: rtl/midi_uart_port_chk.sv
module midi_uart_port_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic             wr_i,
  input logic [7:0]       wdata_i,
  input logic             tx_o,
  input logic             tx_irq_o,
  input logic             rx_irq_o,
  input logic             uart_mode,
  input logic             tx_busy,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] tx_count
);
  assert_ack_queued_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i && wdata_i == 8'h3F) |=> (rx_irq_o && uart_mode));

  assert_reset_flush_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i && wdata_i == 8'hFF) |=>
      (rx_count == CNT_W'(1) && tx_count == '0 && !uart_mode));

  assert_other_cmd_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i && wdata_i != 8'hFF && wdata_i != 8'h3F) |=>
      (uart_mode == $past(uart_mode)));

  assert_line_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> tx_o);

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count <= CNT_W'(DEPTH)) && (tx_count <= CNT_W'(DEPTH)));

  assert_tx_irq_mode_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> uart_mode);

  assert_write_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uart_mode && wr_i && !sel_i) |=> (tx_count <= $past(tx_count)));
endmodule

bind midi_uart_port midi_uart_port_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .wr_i      (wr_i),
  .wdata_i   (wdata_i),
  .tx_o      (tx_o),
  .tx_irq_o  (tx_irq_o),
  .rx_irq_o  (rx_irq_o),
  .uart_mode (uart_mode),
  .tx_busy   (tx_busy),
  .rx_count  (rx_count),
  .tx_count  (tx_count)
);

// File: tb/midi_uart_port_test.sv
module midi_uart_port_test;
  localparam int CPB   = 16;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0, rx_i = 1'b1;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       tx_o, tx_irq_o, rx_irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  midi_uart_port #(.CLKS_PER_BIT(CPB), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rx_i(rx_i), .tx_o(tx_o),
    .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o)
  );

  function automatic logic [7:0] exp_status(int rx_n, int tx_n);
    return {rx_n == 0, tx_n >= DEPTH, 6'b0};
  endfunction

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic host_write(bit sel, logic [7:0] d);
    @(negedge clk);
    sel_i = sel; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0; sel_i = 1'b0;
  endtask

  task automatic host_read(bit sel, output logic [7:0] d);
    @(negedge clk);
    sel_i = sel; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk);
    rd_i = 1'b0; sel_i = 1'b0;
  endtask

  task automatic send_rx(logic [7:0] b, bit good_stop);
    logic [9:0] fr;
    fr = {good_stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rx_i = fr[i];
      repeat (CPB - 1) @(negedge clk);
    end
    @(negedge clk); rx_i = 1'b1;
    repeat (2 * CPB) @(negedge clk);
  endtask

  task automatic capture_tx(output logic [7:0] b, output bit ok);
    int n;
    bit st, sp;
    n = 0; b = '0;
    while (tx_o === 1'b1 && n < 3000) begin @(negedge clk); n++; end
    repeat (CPB / 2) @(negedge clk);
    st = (tx_o === 1'b0);
    for (int i = 0; i < 8; i++) begin
      repeat (CPB) @(negedge clk);
      b[i] = tx_o;
    end
    repeat (CPB) @(negedge clk);
    sp = (tx_o === 1'b1);
    ok = (n < 3000) && st && sp;
  endtask

  task automatic line_quiet(int cyc, output bit ok);
    ok = 1;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (tx_o !== 1'b1) ok = 0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, b;
    logic [7:0] q [6];
    bit ok;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    host_read(1, d);
    check8("R1 status", d, 8'h80);
    check8("R1 line/irq", {tx_o, tx_irq_o, rx_irq_o}, 3'b100);

    // R11 outside UART mode
    host_write(0, 8'h55);
    line_quiet(40, ok);
    check8("R11 tx quiet", ok, 1);
    send_rx(8'h33, 1);
    host_read(1, d);
    check8("R11 rx dropped", d, exp_status(0, 0));

    // R4 unknown command
    host_write(1, 8'h12);
    host_read(1, d);
    check8("R4 status", d, 8'h80);
    check8("R4 irq", {tx_irq_o, rx_irq_o}, 2'b00);

    // R2 enter UART
    host_write(1, 8'h3F);
    host_read(1, d);
    check8("R2 R5 status ack", d, exp_status(1, 0));
    check8("R10 irqs", {tx_irq_o, rx_irq_o}, 2'b11);
    host_read(0, d);
    check8("R2 ack byte", d, 8'hFE);
    host_read(1, d);
    check8("R5 status empty", d, exp_status(0, 0));
    host_read(0, d);
    check8("R12 empty read", d, 8'h00);
    host_read(1, d);
    check8("R12 no change", d, 8'h80);

    // R6 random single bytes
    for (int k = 0; k < 3; k++) begin
      b = 8'($urandom);
      host_write(0, b);
      capture_tx(d, ok);
      check8("R6 frame ok", ok, 1);
      check8("R6 tx byte", d, b);
    end

    // R9 tx full, R6 order
    for (int k = 0; k < 6; k++) q[k] = 8'($urandom);
    for (int k = 0; k < 5; k++) host_write(0, q[k]);
    host_read(1, d);
    check8("R9 R5 tx full status", d, exp_status(0, DEPTH));
    check8("R10 tx irq low", tx_irq_o, 0);
    host_write(0, q[5]);
    for (int k = 0; k < 5; k++) begin
      capture_tx(d, ok);
      check8("R6 burst ok", ok, 1);
      check8("R6 burst order", d, q[k]);
    end
    line_quiet(10 * CPB + 40, ok);
    check8("R9 tx overflow dropped", ok, 1);
    check8("R10 tx irq high", tx_irq_o, 1);

    // R7 random rx
    for (int k = 0; k < 3; k++) begin
      b = 8'($urandom);
      send_rx(b, 1);
      check8("R10 rx irq", rx_irq_o, 1);
      host_read(0, d);
      check8("R7 rx byte", d, b);
    end

    // R8 bad stop then good frame
    send_rx(8'hA5, 0);
    host_read(1, d);
    check8("R8 bad frame dropped", d, 8'h80);
    send_rx(8'h3C, 1);
    host_read(0, d);
    check8("R8 recovery", d, 8'h3C);

    // R9 rx overflow
    for (int k = 0; k < 5; k++) begin
      q[k] = 8'($urandom);
      send_rx(q[k], 1);
    end
    for (int k = 0; k < 4; k++) begin
      host_read(0, d);
      check8("R9 rx kept", d, q[k]);
    end
    host_read(0, d);
    check8("R9 rx discarded", d, 8'h00);

    // R3 reset command
    send_rx(8'h11, 1);
    send_rx(8'h22, 1);
    for (int k = 0; k < 3; k++) host_write(0, 8'h40 + 8'(k));
    host_write(1, 8'hFF);
    host_read(1, d);
    check8("R3 status", d, exp_status(1, 0));
    check8("R3 tx irq off", tx_irq_o, 0);
    host_read(0, d);
    check8("R3 single ack", d, 8'hFE);
    host_read(0, d);
    check8("R3 flushed", d, 8'h00);
    repeat (12 * CPB) @(negedge clk);
    host_write(0, 8'h77);
    line_quiet(12 * CPB, ok);
    check8("R3 R11 tx flushed and ignored", ok, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule